// File: doc/BRIEF.md
# Mailbox Message-Signaled Interrupt Unit

This unit is a bank of write-triggered mailboxes that any bus master can use to raise an interrupt by writing a single word. There are 128 mailboxes of 64 bits each, so the data space is 1 KB. Every mailbox has its own configuration word. That word chooses how an incoming write is merged with the stored value, and which condition on the merged value raises the mailbox's interrupt line.

An interrupt line that has fired stays high until software writes a clear command for that mailbox. This lets a message-signaled interrupt be delivered as a plain memory write. Stored values, configuration words and interrupt status can all be read back through a registered read port.

The write port carries a 2-bit address space code beside the byte address: mailbox data, configuration, clear commands, or an unmapped space.

Top module: `msi_mailbox_unit`

## Requirements
- R1: After reset, every mailbox value, every configuration word and every interrupt line is zero.
- R2: Byte address bits [9:3] select the mailbox, and bits [2:0] are ignored. The space code selects the target: 0 is mailbox data, 1 is configuration, 2 is clear, and 3 is unmapped. Writes to space 3 change nothing, and reads from space 3 return zero.
- R3: Configuration bits [1:0] select the input function applied by a data write. 0 overwrites the value, 1 adds the written value modulo 2^64, 2 ORs it in, and 3 ANDs it in.
- R4: Configuration bits [3:2] select the trigger, which is evaluated on the merged value. 0 fires on every write, 1 fires when the value equals the threshold, 2 fires when the value is greater than or equal to the threshold, and 3 fires when the value is nonzero. The threshold is configuration bits [63:32], zero-extended.
- R5: A firing data write sets that mailbox's interrupt line at the same clock edge that stores the new value. No other line changes.
- R6: An interrupt line stays high through later writes that do not fire. It drops only on a clear-space write to that mailbox with data bit 0 set; a clear write with bit 0 low has no effect.
- R7: A configuration write stores data bits [3:0] and [63:32]. Read-back returns those bits, with every other bit zero.
- R8: Read data appears one clock after rd_space and rd_addr are presented. It holds the mailbox value for space 0, the configuration word for space 1, and the interrupt status in bit 0 for space 2.
- R9: A configuration write changes no mailbox value and no interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_space | input | 2 | Write target space code |
| wr_addr | input | 10 | Write byte address |
| wr_data | input | 64 | Write data |
| rd_space | input | 2 | Read source space code |
| rd_addr | input | 10 | Read byte address |
| rd_data | output | 64 | Registered read data |
| irq_o | output | 128 | One interrupt line per mailbox |

## Verification
The bench builds the block with its default values: 128 mailboxes of 64 bits and a 32-bit threshold. This puts both end indices 0 and 127 in reach, along with the full 64-bit wrap of the add function. Random traffic is confined to a small pool of mailboxes so that configuration changes, merges, triggers and clears repeatedly land on the same mailboxes. Directed cases hit exact threshold equality, the value one below it, AND merges that collapse to zero, and nonzero low address bits.

// File: rtl/msi_mbox_pkg.sv
package msi_mbox_pkg;

    localparam int THR_W   = 32;
    localparam int THR_LSB = 32;

    typedef enum logic [1:0] {
        SP_DATA = 2'd0,
        SP_CFG  = 2'd1,
        SP_CLR  = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        IN_WRITE = 2'd0,
        IN_ADD   = 2'd1,
        IN_OR    = 2'd2,
        IN_AND   = 2'd3
    } infn_e;

    typedef enum logic [1:0] {
        TRG_ANY = 2'd0,
        TRG_EQ  = 2'd1,
        TRG_GE  = 2'd2,
        TRG_NZ  = 2'd3
    } trg_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        trg_e             trg;
        infn_e            infn;
    } cfg_t;

endpackage

// File: rtl/msi_update.sv
module msi_update
    import msi_mbox_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  infn_e              mode,
    input  logic [DATA_W-1:0]  old_val,
    input  logic [DATA_W-1:0]  wr_val,
    output logic [DATA_W-1:0]  new_val
);

    always_comb begin
        unique case (mode)
            IN_WRITE: new_val = wr_val;
            IN_ADD:   new_val = old_val + wr_val;
            IN_OR:    new_val = old_val | wr_val;
            IN_AND:   new_val = old_val & wr_val;
            default:  new_val = wr_val;
        endcase
    end

endmodule

// File: rtl/msi_trigger.sv
module msi_trigger
    import msi_mbox_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  trg_e               mode,
    input  logic [DATA_W-1:0]  value,
    input  logic [THR_W-1:0]   thr,
    output logic               fire
);

    logic [DATA_W-1:0] thr_ext;

    assign thr_ext = {{(DATA_W-THR_W){1'b0}}, thr};

    always_comb begin
        unique case (mode)
            TRG_ANY: fire = 1'b1;
            TRG_EQ:  fire = (value == thr_ext);
            TRG_GE:  fire = (value >= thr_ext);
            TRG_NZ:  fire = (value != '0);
            default: fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/msi_mailbox_unit.sv
module msi_mailbox_unit
    import msi_mbox_pkg::*;
#(
    parameter int NUM_BOX = 128,
    parameter int DATA_W  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_space,
    input  logic [$clog2(NUM_BOX)+2:0]   wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [1:0]                   rd_space,
    input  logic [$clog2(NUM_BOX)+2:0]   rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_BOX-1:0]           irq_o
);

    localparam int IDX_W  = $clog2(NUM_BOX);
    localparam int ADDR_W = IDX_W + 3;

    // state: current (_q) and next (_d)
    logic [DATA_W-1:0]  box_q [NUM_BOX];
    logic [DATA_W-1:0]  box_d [NUM_BOX];
    cfg_t               cfg_q [NUM_BOX];
    cfg_t               cfg_d [NUM_BOX];
    logic [NUM_BOX-1:0] irq_q, irq_d;
    logic [DATA_W-1:0]  rd_q, rd_d;

    logic [IDX_W-1:0]   wr_idx, rd_idx;
    cfg_t               wr_cfg, cfg_in, rd_cfg;
    logic [DATA_W-1:0]  merged;
    logic               fire;

    assign wr_idx = wr_addr[ADDR_W-1:3];
    assign rd_idx = rd_addr[ADDR_W-1:3];
    assign wr_cfg = cfg_q[wr_idx];
    assign rd_cfg = cfg_q[rd_idx];

    assign cfg_in.infn = infn_e'(wr_data[1:0]);
    assign cfg_in.trg  = trg_e'(wr_data[3:2]);
    assign cfg_in.thr  = wr_data[THR_LSB +: THR_W];

    msi_update #(.DATA_W(DATA_W)) u_update (
        .mode    (wr_cfg.infn),
        .old_val (box_q[wr_idx]),
        .wr_val  (wr_data),
        .new_val (merged)
    );

    msi_trigger #(.DATA_W(DATA_W)) u_trigger (
        .mode  (wr_cfg.trg),
        .value (merged),
        .thr   (wr_cfg.thr),
        .fire  (fire)
    );

    // next-state logic
    always_comb begin
        box_d = box_q;
        cfg_d = cfg_q;
        irq_d = irq_q;
        if (wr_en) begin
            unique case (space_e'(wr_space))
                SP_DATA: begin
                    box_d[wr_idx] = merged;
                    if (fire) irq_d[wr_idx] = 1'b1;
                end
                SP_CFG:  cfg_d[wr_idx] = cfg_in;
                SP_CLR:  if (wr_data[0]) irq_d[wr_idx] = 1'b0;
                default: ;
            endcase
        end

        rd_d = '0;
        unique case (space_e'(rd_space))
            SP_DATA: rd_d = box_q[rd_idx];
            SP_CFG: begin
                rd_d[3:0]               = {rd_cfg.trg, rd_cfg.infn};
                rd_d[THR_LSB +: THR_W]  = rd_cfg.thr;
            end
            SP_CLR:  rd_d[0] = irq_q[rd_idx];
            default: rd_d = '0;
        endcase
    end

    // registers, one slice per mailbox
    for (genvar k = 0; k < NUM_BOX; k++) begin : g_box
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                box_q[k] <= '0;
                cfg_q[k] <= '0;
                irq_q[k] <= 1'b0;
            end else begin
                box_q[k] <= box_d[k];
                cfg_q[k] <= cfg_d[k];
                irq_q[k] <= irq_d[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
    assign irq_o   = irq_q;

    // R5: a line can only rise after a data write
    a_r5_rise_needs_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_q & ~$past(irq_q)) != '0) |-> $past(wr_en && wr_space == SP_DATA));

    // R5: a single write moves at most one line
    a_r5_one_line_per_write: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_q ^ $past(irq_q)) <= 1);

    // R6: a line can only fall after a clear command
    a_r6_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq_q & $past(irq_q)) != '0) |-> $past(wr_en && wr_space == SP_CLR && wr_data[0]));

    // R4: trigger mode 0 always leaves the line high
    a_r4_any_write_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_space == SP_DATA && wr_cfg.trg == TRG_ANY) |=> irq_q[$past(wr_idx)]);

    // R9: configuration writes leave interrupt lines alone
    a_r9_cfg_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_space == SP_CFG) |=> (irq_q == $past(irq_q)));

    // R2: reads from the unmapped space return zero
    a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_space == SP_NONE) |=> (rd_data == '0));

endmodule

// File: tb/sim_msi_mailbox_unit.sv
`timescale 1ns/1ps
module sim_msi_mailbox_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_space = '0;
    logic [9:0]   wr_addr = '0;
    logic [63:0]  wr_data = '0;
    logic [1:0]   rd_space = '0;
    logic [9:0]   rd_addr = '0;
    logic [63:0]  rd_data;
    logic [127:0] irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [63:0]  m_box [128];
    logic [63:0]  m_cfg [128];
    logic [127:0] m_irq;

    always #4 clk = ~clk;

    msi_mailbox_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_space(wr_space),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_space(rd_space),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [63:0] f_merge(input logic [1:0] fn, input logic [63:0] o, input logic [63:0] w);
        case (fn)
            2'd0: return w;
            2'd1: return o + w;
            2'd2: return o | w;
            default: return o & w;
        endcase
    endfunction

    function automatic bit f_fire(input logic [1:0] t, input logic [63:0] v, input logic [31:0] thr);
        case (t)
            2'd0: return 1'b1;
            2'd1: return v == {32'd0, thr};
            2'd2: return v >= {32'd0, thr};
            default: return v != 64'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sp, input int idx, input logic [63:0] d,
                      input logic [2:0] low, input string req);
        logic [63:0] nv;
        @(negedge clk);
        wr_en = 1'b1; wr_space = sp; wr_addr = {idx[6:0], low}; wr_data = d;
        case (sp)
            2'd0: begin
                nv = f_merge(m_cfg[idx][1:0], m_box[idx], d);
                m_box[idx] = nv;
                if (f_fire(m_cfg[idx][3:2], nv, m_cfg[idx][63:32])) m_irq[idx] = 1'b1;
            end
            2'd1: m_cfg[idx] = d & 64'hFFFF_FFFF_0000_000F;
            2'd2: if (d[0]) m_irq[idx] = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
        chk(req, irq_o, m_irq);
    endtask

    task automatic rd(input logic [1:0] sp, input int idx, input logic [2:0] low, input string req);
        logic [63:0] e;
        @(negedge clk);
        rd_space = sp; rd_addr = {idx[6:0], low};
        case (sp)
            2'd0: e = m_box[idx];
            2'd1: e = m_cfg[idx];
            2'd2: e = {63'd0, m_irq[idx]};
            default: e = 64'd0;
        endcase
        @(negedge clk);
        chk(req, {64'd0, rd_data}, {64'd0, e});
    endtask

    function automatic logic [63:0] cfgw(input logic [1:0] fn, input logic [1:0] t, input logic [31:0] thr);
        return {thr, 28'd0, t, fn};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int pool [7] = '{0, 1, 2, 3, 5, 126, 127};
        void'($urandom(32'd2024));
        for (int i = 0; i < 128; i++) begin m_box[i] = '0; m_cfg[i] = '0; end
        m_irq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1", irq_o, 128'd0);
        rd(2'd0, 5, 3'd0, "R1");
        rd(2'd1, 127, 3'd0, "R1");
        rd(2'd2, 0, 3'd0, "R1");

        // R4/R5 any-write trigger with overwrite
        wr(2'd0, 3, 64'h55, 3'd0, "R5");
        rd(2'd0, 3, 3'd0, "R3");
        rd(2'd2, 3, 3'd0, "R8");

        // R6 sticky and clear
        wr(2'd2, 3, 64'h2, 3'd0, "R6");
        wr(2'd1, 3, cfgw(2'd0, 2'd1, 32'd9), 3'd0, "R9");
        wr(2'd0, 3, 64'h1, 3'd0, "R6");
        wr(2'd2, 3, 64'h1, 3'd0, "R6");

        // R3 add wraps modulo 2^64
        wr(2'd1, 126, cfgw(2'd1, 2'd3, 32'd0), 3'd0, "R7");
        wr(2'd0, 126, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, "R5");
        wr(2'd0, 126, 64'h2, 3'd0, "R5");
        rd(2'd0, 126, 3'd0, "R3");

        // R4 equality with add
        wr(2'd1, 1, cfgw(2'd1, 2'd1, 32'd10), 3'd0, "R7");
        wr(2'd0, 1, 64'd4, 3'd0, "R4");
        wr(2'd0, 1, 64'd6, 3'd0, "R4");

        // R4 greater-or-equal
        wr(2'd1, 2, cfgw(2'd0, 2'd2, 32'd100), 3'd0, "R7");
        wr(2'd0, 2, 64'd99, 3'd0, "R4");
        wr(2'd0, 2, 64'd100, 3'd0, "R4");

        // R4 nonzero with OR then AND
        wr(2'd1, 0, cfgw(2'd2, 2'd3, 32'd0), 3'd0, "R7");
        wr(2'd0, 0, 64'd0, 3'd0, "R4");
        wr(2'd0, 0, 64'd8, 3'd0, "R4");
        wr(2'd2, 0, 64'd1, 3'd0, "R6");
        wr(2'd1, 0, cfgw(2'd3, 2'd3, 32'd0), 3'd0, "R7");
        wr(2'd0, 0, 64'hF0, 3'd0, "R3");
        rd(2'd0, 0, 3'd0, "R3");

        // R2 low address bits and unmapped space
        wr(2'd0, 5, 64'hDEAD_BEEF, 3'd5, "R2");
        rd(2'd0, 5, 3'd2, "R2");
        wr(2'd3, 5, 64'h1234, 3'd0, "R2");
        rd(2'd0, 5, 3'd0, "R2");
        rd(2'd3, 5, 3'd0, "R2");

        // R7 masked configuration read-back
        wr(2'd1, 127, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, "R7");
        rd(2'd1, 127, 3'd0, "R7");

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int idx;
            int op;
            logic [63:0] d;
            idx = pool[$urandom_range(0, 6)];
            op  = $urandom_range(0, 9);
            d   = ($urandom_range(0, 1) == 1) ? {$urandom, $urandom} : 64'($urandom_range(0, 15));
            if (op < 5)      wr(2'd0, idx, d, 3'($urandom), "R5");
            else if (op < 7) wr(2'd1, idx, cfgw(2'($urandom), 2'($urandom), 32'($urandom_range(0, 20))), 3'd0, "R9");
            else if (op < 8) wr(2'd2, idx, 64'($urandom_range(0, 1)), 3'd0, "R6");
            else             rd(2'($urandom), idx, 3'($urandom), "R8");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule